// File: doc/BRIEF.md
# Horizontal Line Resampler with Three-Tap Filters

This block resizes one row of a picture at a time. Pixels arrive left to right on a valid/ready stream. Each pixel has three 8-bit channels, and each channel is processed on its own. The block produces a row of any integer width from a row of any integer width. It uses an error accumulator that either drops source pixels (reduction) or repeats them (enlargement), and it needs no divider. Destination pixel `j` always takes source pixel `floor((2j+1)*src/(2*dst))`, so the selected pixels are spread as evenly as the grid allows.

Two three-tap filters sit around the resampler: a smoothing filter and a sharpening filter. Their positions swap with the scale direction. When a row is reduced or copied at equal width, smoothing runs on the source row and sharpening runs on the resampled row. When a row is enlarged, sharpening runs on the source row and smoothing runs on the enlarged row. Each filter stores only two earlier pixels. Where a neighbour lies beyond either end of the row, the filter uses the edge pixel in its place.

Every output pixel carries its destination column. A mirror control makes the columns count down, so a writer that places each pixel at its column builds the row right to left. The block moves one pixel per clock: one source pixel per clock when reducing, one destination pixel per clock when enlarging.

Top module: `line_resampler`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high while no input is offered.
- R2: For each row of exactly `src_width` accepted pixels, the block delivers exactly `dst_width` output pixels and no more. The row's last source pixel is consumed together with, or after, its last emitted destination pixel.
- R3: With both filter selects at pass-through (0 or 3), output pixel `j` equals source pixel `floor((2j+1)*src_width/(2*dst_width))`.
- R4: While output is always ready and input is always offered, the resampler takes a source pixel every cycle when `src_width >= dst_width`, and it presents a destination pixel every cycle when `src_width < dst_width`. A whole row completes within `max(src_width,dst_width)+3` cycles.
- R5: `smooth_sel` gives: 0 or 3 pass-through, 1 `(l+2c+r+2)>>2`, 2 `(l+r+1)>>1`. These act on each 8-bit channel. Channel k sits at bits `8k+7:8k` of a pixel.
- R6: `sharp_sel` gives: 0 or 3 pass-through, 1 `floor((4c-l-r+1)/2)`, 2 `3c-l-r`. Each result is clamped to 0..255.
- R7: When `src_width >= dst_width`, smoothing is applied before resampling and sharpening after it. Otherwise sharpening comes first and smoothing second.
- R8: In each filter, the first pixel of a row uses itself as its left neighbour, and the last pixel uses itself as its right neighbour.
- R9: With `mirror` high, output pixel number `j` of a row carries column `dst_width-1-j`. The pixel values come in the same order as without mirror.
- R10: With `mirror` low, the columns count 0 to `dst_width-1`, and a column never reaches `dst_width`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pixel` and `out_x` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_width | input | W | Source row length, at least 1 |
| dst_width | input | W | Destination row length, at least 1 |
| smooth_sel | input | 2 | Smoothing strength select |
| sharp_sel | input | 2 | Sharpening strength select |
| mirror | input | 1 | Count destination columns downward |
| in_valid | input | 1 | Source pixel offered |
| in_ready | output | 1 | Source pixel taken this cycle |
| in_pixel | input | 3*8 | Source pixel, three channels |
| out_valid | output | 1 | Destination pixel offered |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 3*8 | Destination pixel |
| out_x | output | W | Destination column of `out_pixel` |

## Verification
The assertions assume that both widths are non-zero and do not change while a row is still inside the block. They also assume that each row supplies exactly `src_width` pixels, and that an offered input pixel stays offered, unchanged, until it is taken. The stimulus changes the configuration only after the previous row has fully drained. It sends exactly `src_width` pixels per row and holds each one until it is accepted. It throttles `out_ready` at random, except in the throughput runs, where `out_ready` stays high.

// File: rtl/line_resampler_pkg.sv
package line_resampler_pkg;
  parameter int unsigned CH_W = 8;
  localparam int unsigned ACC_W = CH_W + 4;

  typedef logic [CH_W-1:0] chan_t;
  typedef enum logic [1:0] {
    TAP_PASS     = 2'd0,
    TAP_MILD     = 2'd1,
    TAP_STRONG   = 2'd2,
    TAP_PASS_ALT = 2'd3
  } tap_sel_e;

  // Smoothing kernel on one channel, rounded by half an LSB.
  function automatic chan_t smooth_px(input logic [1:0] sel, input chan_t l, input chan_t c,
                                      input chan_t r);
    logic [CH_W+1:0] s;
    s = '0;
    case (tap_sel_e'(sel))
      TAP_MILD: begin
        s = {2'b00, l} + {1'b0, c, 1'b0} + {2'b00, r} + (CH_W+2)'(2);
        return s[CH_W+1:2];
      end
      TAP_STRONG: begin
        s = {2'b00, l} + {2'b00, r} + (CH_W+2)'(1);
        return s[CH_W:1];
      end
      default: return c;
    endcase
  endfunction

  // Sharpening kernel on one channel, clamped to the channel range.
  function automatic chan_t sharp_px(input logic [1:0] sel, input chan_t l, input chan_t c,
                                     input chan_t r);
    logic signed [ACC_W-1:0] lx, cx, rx, v, top;
    lx  = $signed({{(ACC_W-CH_W){1'b0}}, l});
    cx  = $signed({{(ACC_W-CH_W){1'b0}}, c});
    rx  = $signed({{(ACC_W-CH_W){1'b0}}, r});
    top = $signed({{(ACC_W-CH_W){1'b0}}, {CH_W{1'b1}}});
    case (tap_sel_e'(sel))
      TAP_MILD: begin
        v = (cx <<< 2) - lx - rx + $signed(ACC_W'(1));
        v = v >>> 1;
      end
      TAP_STRONG: v = (cx <<< 1) + cx - lx - rx;
      default: v = cx;
    endcase
    if (v < $signed(ACC_W'(0))) return '0;
    if (v > top) return '1;
    return v[CH_W-1:0];
  endfunction
endpackage

// File: rtl/line_resampler_filter.sv
module line_resampler_filter
  import line_resampler_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned CHANNELS = 3,
  parameter int unsigned TAG_W    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             len,
  input  logic                     use_sharp,
  input  logic [1:0]               smooth_sel,
  input  logic [1:0]               sharp_sel,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CHANNELS*CH_W-1:0] in_pix,
  input  logic [TAG_W-1:0]         in_tag,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CHANNELS*CH_W-1:0] out_pix,
  output logic [TAG_W-1:0]         out_tag
);
  localparam int unsigned PIX_W = CHANNELS * CH_W;

  logic             have_c, c_first, c_last;
  logic [PIX_W-1:0] c_q, l_q;
  logic [TAG_W-1:0] tag_q;
  logic [W-1:0]     pos_q;

  logic             in_fire, out_fire, in_first, in_last;
  logic [PIX_W-1:0] left_px, right_px;

  assign in_first = (pos_q == '0);
  assign in_last  = (pos_q == len - W'(1));
  assign in_ready = !have_c || out_ready;
  assign out_valid = have_c && (in_valid || c_last);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // Edge replication: the missing neighbour becomes the centre pixel.
  assign left_px  = c_first ? c_q : l_q;
  assign right_px = c_last ? c_q : in_pix;
  assign out_tag  = tag_q;

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    chan_t lk, ck, rk;
    assign lk = left_px[k*CH_W +: CH_W];
    assign ck = c_q[k*CH_W +: CH_W];
    assign rk = right_px[k*CH_W +: CH_W];
    assign out_pix[k*CH_W +: CH_W] = use_sharp ? sharp_px(sharp_sel, lk, ck, rk)
                                               : smooth_px(smooth_sel, lk, ck, rk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_c  <= 1'b0;
      c_first <= 1'b0;
      c_last  <= 1'b0;
      c_q     <= '0;
      l_q     <= '0;
      tag_q   <= '0;
      pos_q   <= '0;
    end else if (in_fire) begin
      have_c  <= 1'b1;
      l_q     <= c_q;
      c_q     <= in_pix;
      tag_q   <= in_tag;
      c_first <= in_first;
      c_last  <= in_last;
      pos_q   <= in_last ? '0 : pos_q + W'(1);
    end else if (out_fire) begin
      have_c <= 1'b0;
    end
  end

  // A pixel accepted into a busy centre slot must push the old centre out.
  assert_no_lost_centre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && have_c) |-> out_fire);
endmodule

// File: rtl/line_resampler_stepper.sv
module line_resampler_stepper #(
  parameter int unsigned W     = 12,
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     dx,
  input  logic [W-1:0]     dy,
  input  logic             mirror,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [W-1:0]     in_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic [W-1:0]     out_x
);
  localparam int unsigned EW = W + 2;

  logic          fresh_q;
  logic [EW-1:0] err_q;
  logic [W-1:0]  cnt_q;

  logic [EW-1:0] dx2, dy2, err_cur, err_sum, err_next;
  logic [W-1:0]  cnt_cur;
  logic          emit, consume, advance, last_src, reduce_mode;

  assign dx2         = {1'b0, dx, 1'b0};
  assign dy2         = {1'b0, dy, 1'b0};
  assign reduce_mode = (dx >= dy);
  assign err_cur     = fresh_q ? EW'(dx) : err_q;
  assign cnt_cur     = fresh_q ? '0 : cnt_q;

  // Error term: emit while below 2*dy, consume once the sum reaches 2*dy.
  assign emit     = (err_cur < dy2);
  assign err_sum  = err_cur + (emit ? dx2 : '0);
  assign consume  = (err_sum >= dy2);
  assign err_next = consume ? (err_sum - dy2) : err_sum;
  assign last_src = (in_idx == dx - W'(1));

  assign advance   = in_valid && (!emit || out_ready);
  assign in_ready  = consume && (!emit || out_ready);
  assign out_valid = in_valid && emit;
  assign out_pix   = in_pix;
  assign out_x     = mirror ? (dy - W'(1) - cnt_cur) : cnt_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      err_q   <= '0;
      cnt_q   <= '0;
    end else if (advance) begin
      if (consume && last_src) begin
        fresh_q <= 1'b1;
        err_q   <= '0;
        cnt_q   <= '0;
      end else begin
        fresh_q <= 1'b0;
        err_q   <= err_next;
        cnt_q   <= cnt_cur + W'(emit);
      end
    end
  end

  assert_reduce_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reduce_mode && in_valid && out_ready) |-> in_ready);
  assert_enlarge_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reduce_mode && in_valid) |-> out_valid);
  assert_row_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && last_src) |-> ((cnt_cur + W'(emit)) == dy));
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_cur < dy));
endmodule

// File: rtl/line_resampler.sv
module line_resampler
  import line_resampler_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned CHANNELS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             src_width,
  input  logic [W-1:0]             dst_width,
  input  logic [1:0]               smooth_sel,
  input  logic [1:0]               sharp_sel,
  input  logic                     mirror,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CHANNELS*CH_W-1:0] in_pixel,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CHANNELS*CH_W-1:0] out_pixel,
  output logic [W-1:0]             out_x
);
  localparam int unsigned PIX_W = CHANNELS * CH_W;

  logic             reduce_mode;
  logic [W-1:0]     src_idx;
  logic             in_fire, src_last;

  logic             a_valid, a_ready;
  logic [PIX_W-1:0] a_pix;
  logic [W-1:0]     a_idx;
  logic             s_valid, s_ready;
  logic [PIX_W-1:0] s_pix;
  logic [W-1:0]     s_x;

  assign reduce_mode = (src_width >= dst_width);
  assign in_fire     = in_valid && in_ready;
  assign src_last    = (src_idx == src_width - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_idx <= '0;
    else if (in_fire) src_idx <= src_last ? '0 : src_idx + W'(1);
  end

  // Stage before the resampler: smoothing on reduction, sharpening on enlargement.
  line_resampler_filter #(.W(W), .CHANNELS(CHANNELS), .TAG_W(W)) u_pre (
    .clk(clk), .rst_n(rst_n), .len(src_width), .use_sharp(!reduce_mode),
    .smooth_sel(smooth_sel), .sharp_sel(sharp_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pixel), .in_tag(src_idx),
    .out_valid(a_valid), .out_ready(a_ready), .out_pix(a_pix), .out_tag(a_idx)
  );

  line_resampler_stepper #(.W(W), .PIX_W(PIX_W)) u_step (
    .clk(clk), .rst_n(rst_n), .dx(src_width), .dy(dst_width), .mirror(mirror),
    .in_valid(a_valid), .in_ready(a_ready), .in_pix(a_pix), .in_idx(a_idx),
    .out_valid(s_valid), .out_ready(s_ready), .out_pix(s_pix), .out_x(s_x)
  );

  // Stage after the resampler: the other filter of the pair.
  line_resampler_filter #(.W(W), .CHANNELS(CHANNELS), .TAG_W(W)) u_post (
    .clk(clk), .rst_n(rst_n), .len(dst_width), .use_sharp(reduce_mode),
    .smooth_sel(smooth_sel), .sharp_sel(sharp_sel),
    .in_valid(s_valid), .in_ready(s_ready), .in_pix(s_pix), .in_tag(s_x),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pixel), .out_tag(out_x)
  );

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_x)));
  assert_x_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x < dst_width));
endmodule

// File: tb/line_resampler_test.sv
module line_resampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 12;
  localparam int CH = 3;
  localparam int PW = CH * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  src_width, dst_width;
  logic [1:0]    smooth_sel, sharp_sel;
  logic          mirror, in_valid, in_ready, out_valid, out_ready;
  logic [PW-1:0] in_pixel, out_pixel;
  logic [W-1:0]  out_x;

  int checks = 0;
  int fails  = 0;
  bit aborted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_resampler #(.W(W), .CHANNELS(CH)) uut (
    .clk(clk), .rst_n(rst_n), .src_width(src_width), .dst_width(dst_width),
    .smooth_sel(smooth_sel), .sharp_sel(sharp_sel), .mirror(mirror),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel), .out_x(out_x)
  );

  function automatic int clamp8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // Kernels written from the requirement text (R5, R6).
  function automatic int tap(bit sharpen, int sel, int l, int c, int r);
    int t;
    if (!sharpen) begin
      if (sel == 1) return (l + 2*c + r + 2) / 4;
      if (sel == 2) return (l + r + 1) / 2;
      return c;
    end
    if (sel == 1) begin
      t = 4*c - l - r + 1;
      if (t < 0) return 0;
      return clamp8(t / 2);
    end
    if (sel == 2) return clamp8(3*c - l - r);
    return c;
  endfunction

  task automatic filt(input bit sh, input int sel, input int n, input logic [PW-1:0] a[64],
                      output logic [PW-1:0] o[64]);
    for (int i = 0; i < 64; i++) o[i] = '0;
    for (int i = 0; i < n; i++) begin
      int li, ri;
      li = (i == 0) ? i : i - 1;       // R8 left edge
      ri = (i == n - 1) ? i : i + 1;   // R8 right edge
      for (int k = 0; k < CH; k++)
        o[i][8*k +: 8] = 8'(tap(sh, sel, int'(a[li][8*k +: 8]), int'(a[i][8*k +: 8]),
                                int'(a[ri][8*k +: 8])));
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_line(input int dx, input int dy, input int sm, input int sh,
                          input bit mir, input bit full, output int cyc);
    logic [PW-1:0] src[64], mid[64], scl[64], expv[64];
    bit reduce, sm_id, sh_id, prev_stall;
    logic [PW-1:0] prev_pix;
    logic [W-1:0]  prev_x;
    int sent, got, pick, ex;
    string lab;
    reduce = (dx >= dy);
    sm_id = (sm == 0 || sm == 3);
    sh_id = (sh == 0 || sh == 3);
    for (int i = 0; i < 64; i++) begin
      src[i] = '0;
      for (int k = 0; k < CH; k++) begin
        pick = $urandom_range(0, 5);
        src[i][8*k +: 8] = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd255 : 8'($urandom_range(0, 255));
      end
    end
    // R7: filter order depends on scale direction.
    filt(!reduce, reduce ? sm : sh, dx, src, mid);
    for (int j = 0; j < 64; j++) scl[j] = '0;
    for (int j = 0; j < dy; j++) scl[j] = mid[((2*j + 1) * dx) / (2 * dy)];  // R3 mapping
    filt(reduce, reduce ? sh : sm, dy, scl, expv);

    @(negedge clk);
    src_width = W'(dx); dst_width = W'(dy);
    smooth_sel = 2'(sm); sharp_sel = 2'(sh); mirror = mir;
    sent = 0; got = 0; cyc = 0; prev_stall = 0; prev_pix = '0; prev_x = '0;
    while (!(sent == dx && got == dy)) begin
      @(negedge clk);
      in_valid  = (sent < dx);
      in_pixel  = (sent < dx) ? src[sent] : '0;
      out_ready = full ? 1'b1 : ($urandom_range(0, 3) != 0);
      #1;
      if (prev_stall)
        check(out_valid && out_pixel == prev_pix && out_x == prev_x, "R11", "held output",
              {out_valid, out_pixel}, {1'b1, prev_pix});
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        if (got < dy) begin
          if (sm_id && sh_id) lab = "R3";
          else if (got == 0 || got == dy - 1) lab = "R8";
          else if (sh_id) lab = "R5";
          else if (sm_id) lab = "R6";
          else lab = "R7";
          check(out_pixel == expv[got], lab, $sformatf("pixel %0d of %0dx%0d s%0d h%0d",
                got, dx, dy, sm, sh), out_pixel, expv[got]);
          ex = mir ? dy - 1 - got : got;
          check(int'(out_x) == ex, mir ? "R9" : "R10", "column", out_x, ex);
        end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_pix = out_pixel;
      prev_x = out_x;
      cyc++;
      if (cyc > 2000) begin
        check(1'b0, "R2", "watchdog on row", got, dy);
        aborted = 1;
        break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    for (int t = 0; t < 3; t++) begin
      #1;
      if (out_valid) got++;
      @(negedge clk);
    end
    check(got == dy, "R2", "output count", got, dy);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(1'b0, "R2", "global watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    int widths[5] = '{1, 2, 3, 5, 8};
    int pairs[7][2] = '{'{16, 5}, '{5, 16}, '{12, 12}, '{1, 9}, '{9, 1}, '{40, 17}, '{17, 40}};
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_pixel = '0;
    src_width = W'(1); dst_width = W'(1); smooth_sel = '0; sharp_sel = '0; mirror = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int a = 0; a < 5 && !aborted; a++)
      for (int b = 0; b < 5 && !aborted; b++)
        for (int s = 0; s < 4 && !aborted; s++)
          for (int h = 0; h < 4 && !aborted; h++)
            for (int m = 0; m < 2 && !aborted; m++)
              run_line(widths[a], widths[b], s, h, m[0], 1'b0, cyc);

    for (int p = 0; p < 7 && !aborted; p++) begin
      int mx;
      mx = (pairs[p][0] > pairs[p][1]) ? pairs[p][0] : pairs[p][1];
      run_line(pairs[p][0], pairs[p][1], p % 4, (p + 1) % 4, p[0], 1'b1, cyc);
      check(cyc <= mx + 3, "R4", "row cycles at full rate", cyc, mx + 3);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule